// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Management Bus

This block is a two-wire bus slave that holds the eight control bytes of a clock generator. A host writes them with an indexed block transfer: it sends the device address, a starting index, a byte count, and then that many data bytes. A host reads them by sending the device address and an index, then a repeated START and the read address. The slave replies with a count byte and then the register bytes, starting at the index.

Both bus lines are sampled by the system clock through synchronizers. START, repeated START and STOP are found on the synchronized lines. The slave pulls SDA low for ACK and for data bits. All register bytes are presented in parallel to the clock-control logic. The last byte is read-only and carries the vendor and revision nibbles from constant inputs. Two bytes, and some bits of other bytes, are reserved.

Top module: `smbreg_ctl`

## Requirements
- R1: The slave ACKs the address byte 0xD2 (write) and 0xD3 (read) only. After any other address it ACKs nothing more and changes no register until the next START.
- R2: A block write is START, 0xD2, index N, count X, then X data bytes. The data bytes are stored at N, N+1, and so on. The slave ACKs the address, the index, the count and each of the X data bytes.
- R3: A data byte that arrives after X bytes of a write have been stored is NACKed and is not stored.
- R4: A block read is START, 0xD2, index N, repeated START, 0xD3. The slave then sends the count byte 0x08, followed by the bytes at N, N+1, and so on, MSB first. It sends the next byte whenever the host ACKs, and it changes SDA only while SCL is low.
- R5: The index pointer is taken modulo 8. An index byte of 8 or more selects index mod 8. Reads and writes that pass byte 7 wrap to byte 0.
- R6: Reset values are: byte 0 = 0xFF, byte 1 = 0xFE, byte 2 = 0x60, byte 3 = 0x0F, byte 4 = 0x80, bytes 5 and 6 = 0x00. SDA is released during and after reset.
- R7: The writable bits are: all bits of bytes 0, 1 and 3; mask 0xE5 in byte 2; mask 0xE0 in byte 4; no bits in bytes 5, 6 and 7. Writes to any other bit are ignored, and those bits read back as 0. Byte 7 always reads {rev_id, vendor_id}, with rev_id in bits 7:4.
- R8: A STOP or START that arrives in the middle of a byte, after 1 to 7 of its bits, ends the transfer and stores nothing from the partial byte.
- R9: After the host NACKs a read byte, the slave releases SDA and drives nothing until the next START.
- R10: Output ctl_bytes[8i+7:8i] always holds the value that a read of byte i returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND of all drivers) |
| vendor_id | input | 4 | Constant vendor nibble, shown in bits 3:0 of byte 7 |
| rev_id | input | 4 | Constant revision nibble, shown in bits 7:4 of byte 7 |
| sda_pull_low | output | 1 | 1 = pull SDA low, 0 = release it |
| ctl_bytes | output | 64 | All register bytes, byte i in bits 8i+7:8i |

## Verification
A fault in the index pointer shows up at the ports within one transfer. A write lands in the wrong byte of ctl_bytes, and a read returns a neighbouring byte or fails to wrap at byte 7. A wrong byte-count or framing state changes the level on the ninth clock of a byte: an expected ACK is missing, a byte past the count is ACKed, or SDA is still held after a NACK. Each of these can be seen in the same byte where the fault starts. A commit taken from a partial byte, or a mask fault, shows in ctl_bytes right after the bit that caused it.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX,
        LK_RX_END,
        LK_ACK,
        LK_TX,
        LK_TX_ACK,
        LK_IGNORE
    } link_state_t;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_INDEX,
        RL_COUNT,
        RL_DATA
    } rx_role_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Value each storage byte takes in reset
    function automatic logic [BYTE_W-1:0] reg_default(int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hFE;
            2:       return 8'h60;
            3:       return 8'h0F;
            4:       return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    // Bits a host write may change; all other bits hold 0
    function automatic logic [BYTE_W-1:0] reg_wmask(int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hFF;
            2:       return 8'hE5;
            3:       return 8'hFF;
            4:       return 8'hE0;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbreg_line_sync.sv
module smbreg_line_sync
    import smbreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_p    <= scl_pipe[STAGES-1];
            sda_p    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/smbreg_link.sv
module smbreg_link
    import smbreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 8,
    parameter int         IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_low,
    output link_state_t       state_o
);
    localparam logic [BYTE_W-1:0] CNT_BYTE = BYTE_W'(NUM_REGS);

    link_state_t       state;
    rx_role_t          role;
    logic [3:0]        bitcnt;
    logic [6:0]        rx_sr;
    logic [6:0]        tx_sr;
    logic [IDX_W-1:0]  ptr;
    logic [BYTE_W-1:0] remain;
    logic              ack_pend;
    logic              go_tx;
    logic              host_ack;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_end;

    assign rx_byte  = {rx_sr, evt.sda};
    assign byte_end = (state == LK_RX) && evt.scl_rise && (bitcnt == 4'd7)
                      && !evt.start && !evt.stop;
    assign wr_en    = byte_end && (role == RL_DATA) && (remain != '0);
    assign wr_idx   = ptr;
    assign wr_data  = rx_byte;
    assign rd_idx   = ptr;
    assign state_o  = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LK_IDLE;
            role     <= RL_ADDR;
            bitcnt   <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            ptr      <= '0;
            remain   <= '0;
            ack_pend <= 1'b0;
            go_tx    <= 1'b0;
            host_ack <= 1'b0;
            sda_low  <= 1'b0;
        end else if (evt.stop) begin
            state   <= LK_IDLE;
            sda_low <= 1'b0;
        end else if (evt.start) begin
            state   <= LK_RX;
            role    <= RL_ADDR;
            bitcnt  <= '0;
            go_tx   <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            case (state)
                LK_RX: begin
                    if (evt.scl_rise) begin
                        rx_sr  <= rx_byte[6:0];
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            state <= LK_RX_END;
                            go_tx <= 1'b0;
                            case (role)
                                RL_ADDR: begin
                                    if (rx_byte[7:1] == DEV_ADDR) begin
                                        ack_pend <= 1'b1;
                                        go_tx    <= rx_byte[0];
                                        role     <= RL_INDEX;
                                    end else begin
                                        ack_pend <= 1'b0;
                                    end
                                end
                                RL_INDEX: begin
                                    ptr      <= rx_byte[IDX_W-1:0];
                                    ack_pend <= 1'b1;
                                    role     <= RL_COUNT;
                                end
                                RL_COUNT: begin
                                    remain   <= rx_byte;
                                    ack_pend <= 1'b1;
                                    role     <= RL_DATA;
                                end
                                default: begin
                                    if (remain != '0) begin
                                        ack_pend <= 1'b1;
                                        remain   <= remain - 8'd1;
                                        ptr      <= ptr + IDX_W'(1);
                                    end else begin
                                        ack_pend <= 1'b0;
                                    end
                                end
                            endcase
                        end
                    end
                end
                LK_RX_END: begin
                    if (evt.scl_fall) begin
                        if (ack_pend) begin
                            sda_low <= 1'b1;
                            state   <= LK_ACK;
                        end else begin
                            state <= LK_IGNORE;
                        end
                    end
                end
                LK_ACK: begin
                    if (evt.scl_fall) begin
                        bitcnt <= '0;
                        if (go_tx) begin
                            sda_low <= ~CNT_BYTE[7];
                            tx_sr   <= CNT_BYTE[6:0];
                            state   <= LK_TX;
                        end else begin
                            sda_low <= 1'b0;
                            state   <= LK_RX;
                        end
                    end
                end
                LK_TX: begin
                    if (evt.scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (evt.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_low  <= 1'b0;
                            host_ack <= 1'b0;
                            state    <= LK_TX_ACK;
                        end else begin
                            sda_low <= ~tx_sr[6];
                            tx_sr   <= {tx_sr[5:0], 1'b0};
                        end
                    end
                end
                LK_TX_ACK: begin
                    if (evt.scl_rise) begin
                        host_ack <= ~evt.sda;
                    end else if (evt.scl_fall) begin
                        if (host_ack) begin
                            sda_low <= ~rd_data[7];
                            tx_sr   <= rd_data[6:0];
                            ptr     <= ptr + IDX_W'(1);
                            bitcnt  <= '0;
                            state   <= LK_TX;
                        end else begin
                            state <= LK_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank
    import smbreg_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [3:0]                 vendor_id,
    input  logic [3:0]                 rev_id,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [BYTE_W*NUM_REGS-1:0] image
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        if (i == NUM_REGS - 1) begin : g_id
            assign image[BYTE_W*i +: BYTE_W] = {rev_id, vendor_id};
        end else begin : g_rw
            localparam logic [BYTE_W-1:0] DEF = reg_default(i);
            localparam logic [BYTE_W-1:0] MSK = reg_wmask(i);
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= DEF;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    q <= (q & ~MSK) | (wr_data & MSK);
                end
            end
            assign image[BYTE_W*i +: BYTE_W] = q;
        end
    end

    assign rd_data = image[BYTE_W*rd_idx +: BYTE_W];
endmodule

// File: rtl/smbreg_ctl.sv
module smbreg_ctl
    import smbreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    parameter int         NUM_REGS    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic [3:0]                 vendor_id,
    input  logic [3:0]                 rev_id,
    output logic                       sda_pull_low,
    output logic [BYTE_W*NUM_REGS-1:0] ctl_bytes
);
    localparam int IDX_W = $clog2(NUM_REGS);

    bus_evt_t          evt;
    link_state_t       link_state;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_data;

    smbreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    smbreg_link #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_link (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sda_low (sda_pull_low),
        .state_o (link_state)
    );

    smbreg_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .vendor_id (vendor_id),
        .rev_id    (rev_id),
        .rd_data   (rd_data),
        .image     (ctl_bytes)
    );
endmodule

// File: rtl/smbreg_ctl_chk.sv
module smbreg_ctl_chk
    import smbreg_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic                       clk,
    input logic                       rst,
    input bus_evt_t                   evt,
    input link_state_t                link_state,
    input logic                       sda_pull_low,
    input logic [BYTE_W*NUM_REGS-1:0] ctl_bytes
);
    // R6
    reset_image_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl_bytes[7:0] == reg_default(0) && ctl_bytes[15:8] == reg_default(1)
                        && ctl_bytes[23:16] == reg_default(2) && ctl_bytes[31:24] == reg_default(3)
                        && ctl_bytes[39:32] == reg_default(4) && !sda_pull_low));

    // R4
    sda_when_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_low) |-> !evt.scl);

    // R2
    commit_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_bytes) |-> $past(evt.scl_rise));

    // R8
    no_commit_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.start || evt.stop) |=> $stable(ctl_bytes));

    // R9
    quiet_when_ignoring_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(link_state == LK_IGNORE) && link_state == LK_IGNORE) |-> !sda_pull_low);
endmodule

bind smbreg_ctl smbreg_ctl_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .link_state   (link_state),
    .sda_pull_low (sda_pull_low),
    .ctl_bytes    (ctl_bytes)
);

// File: tb/smbreg_ctl_tb.sv
module smbreg_ctl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_scl;
    logic        host_sda;
    logic        sda_pull_low;
    logic [63:0] ctl_bytes;
    logic [3:0]  vendor_id = 4'h1;
    logic [3:0]  rev_id    = 4'h3;
    logic        sda_line;

    always #2 clk = ~clk;

    assign sda_line = host_sda & ~sda_pull_low;

    smbreg_ctl u_dut (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (host_scl),
        .sda_in       (sda_line),
        .vendor_id    (vendor_id),
        .rev_id       (rev_id),
        .sda_pull_low (sda_pull_low),
        .ctl_bytes    (ctl_bytes)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // {index, data0, data1, expected0, expected1}
    localparam logic [39:0] VEC [6] = '{
        40'h00_5A_C3_5A_C3,
        40'h02_FF_00_E5_00,
        40'h04_FF_FF_E0_00,
        40'h06_AB_12_00_31,
        40'h07_00_77_31_77,
        40'h0B_81_3C_81_20
    };

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(int i);
        return ctl_bytes[8*i +: 8];
    endfunction

    task automatic bus_start();
        host_sda = 1'b1; host_scl = 1'b1; wt(8);
        host_sda = 1'b0; wt(8);
        host_scl = 1'b0; wt(4);
    endtask

    task automatic bus_restart();
        host_sda = 1'b1; wt(8);
        host_scl = 1'b1; wt(8);
        host_sda = 1'b0; wt(8);
        host_scl = 1'b0; wt(4);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wt(8);
        host_scl = 1'b1; wt(8);
        host_sda = 1'b1; wt(8);
    endtask

    task automatic put_bits(logic [7:0] v, int n);
        for (int i = 7; i > 7 - n; i--) begin
            host_sda = v[i]; wt(8);
            host_scl = 1'b1; wt(12);
            host_scl = 1'b0; wt(4);
        end
    endtask

    task automatic put_byte(logic [7:0] v, output logic ack);
        put_bits(v, 8);
        host_sda = 1'b1; wt(8);
        host_scl = 1'b1; wt(6);
        ack = ~sda_line; wt(6);
        host_scl = 1'b0; wt(4);
    endtask

    task automatic get_byte(logic ack_it, output logic [7:0] v);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(8);
            host_scl = 1'b1; wt(6);
            v[i] = sda_line; wt(6);
            host_scl = 1'b0; wt(4);
        end
        host_sda = ack_it ? 1'b0 : 1'b1; wt(8);
        host_scl = 1'b1; wt(12);
        host_scl = 1'b0; wt(4);
        host_sda = 1'b1;
    endtask

    task automatic write2(logic [7:0] idx, logic [7:0] d0, logic [7:0] d1, output logic ok);
        logic a;
        ok = 1'b1;
        bus_start();
        put_byte(8'hD2, a); ok &= a;
        put_byte(idx, a);   ok &= a;
        put_byte(8'h02, a); ok &= a;
        put_byte(d0, a);    ok &= a;
        put_byte(d1, a);    ok &= a;
        bus_stop();
    endtask

    task automatic read_open(logic [7:0] idx, output logic ok);
        logic a;
        ok = 1'b1;
        bus_start();
        put_byte(8'hD2, a); ok &= a;
        put_byte(idx, a);   ok &= a;
        bus_restart();
        put_byte(8'hD3, a); ok &= a;
    endtask

    initial begin
        wt(150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic        ok;
        logic        a;
        logic [7:0]  v;
        logic [63:0] snap;

        rst = 1'b1; host_scl = 1'b1; host_sda = 1'b1;
        wt(6);
        rst = 1'b0;
        wt(6);

        // R6 reset values, R7 reserved and identity bytes, R10 port image
        chk8("R6 byte0 reset", byte_of(0), 8'hFF);
        chk8("R6 byte1 reset", byte_of(1), 8'hFE);
        chk8("R6 byte2 reset", byte_of(2), 8'h60);
        chk8("R6 byte3 reset", byte_of(3), 8'h0F);
        chk8("R6 byte4 reset", byte_of(4), 8'h80);
        chk8("R7 byte5 reset", byte_of(5), 8'h00);
        chk8("R7 byte6 reset", byte_of(6), 8'h00);
        chk8("R7 R10 byte7 id", byte_of(7), 8'h31);
        chk8("R6 sda released", {7'd0, sda_pull_low}, 8'h00);

        // Table walk: R2 writes, R4 reads, R5 wrap, R7 masks, R10 port image
        for (int k = 0; k < 6; k++) begin
            logic [7:0] idx, d0, d1, e0, e1;
            {idx, d0, d1, e0, e1} = VEC[k];
            write2(idx, d0, d1, ok);
            chk8("R2 write acks", {7'd0, ok}, 8'h01);
            chk8("R10 R5 port byte", byte_of(int'(idx[2:0])), e0);
            read_open(idx, ok);
            chk8("R4 read acks", {7'd0, ok}, 8'h01);
            get_byte(1'b1, v); chk8("R4 count byte", v, 8'h08);
            get_byte(1'b1, v); chk8("R4 R7 first data", v, e0);
            get_byte(1'b0, v); chk8("R5 R7 second data", v, e1);
            bus_stop();
        end

        // R1: foreign address gets no ACK and nothing after it
        snap = ctl_bytes;
        bus_start();
        put_byte(8'hA4, a); chk8("R1 foreign addr nack", {7'd0, a}, 8'h00);
        put_byte(8'h00, a); chk8("R1 idle after foreign", {7'd0, a}, 8'h00);
        put_byte(8'h55, a); chk8("R1 still idle", {7'd0, a}, 8'h00);
        bus_stop();
        n_cmp++;
        if (ctl_bytes !== snap) begin
            n_bad++;
            $display("FAIL R1 registers touched actual=%016h expected=%016h", ctl_bytes, snap);
        end

        // R3: byte past the count is refused
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h01, a);
        put_byte(8'h01, a);
        put_byte(8'h11, a); chk8("R3 counted byte ack", {7'd0, a}, 8'h01);
        put_byte(8'h22, a); chk8("R3 extra byte nack", {7'd0, a}, 8'h00);
        bus_stop();
        chk8("R3 byte1 stored", byte_of(1), 8'h11);
        chk8("R3 byte2 untouched", byte_of(2), 8'hE5);

        // R8: STOP in mid-byte
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h00, a);
        put_byte(8'h01, a);
        put_bits(8'h00, 4);
        bus_stop();
        chk8("R8 stop abort byte0", byte_of(0), 8'h77);

        // R8: repeated START in mid-byte, then a read from the held index
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h00, a);
        put_byte(8'h02, a);
        put_bits(8'h00, 3);
        bus_restart();
        put_byte(8'hD3, a); chk8("R8 R4 read after abort ack", {7'd0, a}, 8'h01);
        get_byte(1'b1, v);  chk8("R8 R4 count", v, 8'h08);
        get_byte(1'b0, v);  chk8("R8 byte0 via read", v, 8'h77);
        bus_stop();
        chk8("R8 start abort byte0", byte_of(0), 8'h77);

        // R5 read wrap across byte 7, R9 silence after NACK
        read_open(8'h06, ok);
        chk8("R5 read open acks", {7'd0, ok}, 8'h01);
        get_byte(1'b1, v); chk8("R5 count", v, 8'h08);
        get_byte(1'b1, v); chk8("R5 byte6", v, 8'h00);
        get_byte(1'b1, v); chk8("R5 byte7", v, 8'h31);
        get_byte(1'b1, v); chk8("R5 wrap byte0", v, 8'h77);
        get_byte(1'b0, v); chk8("R5 wrap byte1", v, 8'h11);
        get_byte(1'b0, v); chk8("R9 released after nack", v, 8'hFF);
        bus_stop();
        chk8("R9 sda idle", {7'd0, sda_pull_low}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule